// File: doc/BRIEF.md
# Predicated Vector Lane Arithmetic Unit

This block is the integer execution stage of a wide vector core that has no separate scalar unit. Every instruction goes through sixteen identical 32-bit lanes. Either operand may be marked as a scalar. In that case the word in lane 0 of that operand bus is copied to every lane before the operation, so a single instruction can combine a vector with a scalar. An instruction marked scalar-only computes its result in lane 0 alone.

Writeback is decided per lane. When predication is on, a 16-bit mask selects the lanes that commit their result. Lanes that are not selected pass through the previous destination value, which the register file feeds back on a dedicated bus. One instruction is accepted per cycle, in order. The merged result, a per-lane write-enable vector and a valid strobe are registered one cycle after issue.

Top module: `vec_lane_alu`

## Requirements
- R1: Opcode 0 computes a+b and opcode 1 computes a-b, per lane, both modulo 2^32.
- R2: Opcode 2 computes a&b, opcode 3 computes a|b and opcode 4 computes a^b, per lane.
- R3: Opcode 5 shifts a left and opcode 6 shifts a right logically (zero fill). The shift amount is bits [4:0] of b, and the higher bits of b are ignored.
- R4: Opcode 7 gives 1 when a is less than b as signed two's-complement numbers, and 0 otherwise.
- R5: When a_scalar_i or b_scalar_i is set, word 0 of that operand bus (bits [31:0]) is used in every lane, and the other words of that bus have no effect on the result.
- R6: A scalar-only instruction (scalar_op_i=1) gives res_wen_o=16'h0001 for any mask and any predicate setting. Lane 0 carries the lane-0 result and lanes 1..15 carry their dst_old_i words.
- R7: A vector instruction with pred_en_i=1 gives res_wen_o equal to mask_i. Every lane whose mask bit is 0 outputs its dst_old_i word, and every lane whose mask bit is 1 outputs its new result.
- R8: A vector instruction with pred_en_i=0 gives res_wen_o=16'hFFFF, and every lane carries its new result.
- R9: res_valid_o is high exactly in the cycle after a cycle with issue_i high. In a cycle where res_valid_o is low, res_wen_o is 0.
- R10: While rst_n is low, res_valid_o, res_wen_o and res_data_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | An instruction is presented this cycle |
| op_i | input | 3 | Operation code (0 add, 1 sub, 2 and, 3 or, 4 xor, 5 shl, 6 shr, 7 slt) |
| a_data_i | input | 512 | Operand A, lane l in bits [32l+31:32l] |
| a_scalar_i | input | 1 | Broadcast word 0 of operand A |
| b_data_i | input | 512 | Operand B, same layout |
| b_scalar_i | input | 1 | Broadcast word 0 of operand B |
| scalar_op_i | input | 1 | Scalar-only instruction, lane 0 writes |
| pred_en_i | input | 1 | Apply mask_i to writeback |
| mask_i | input | 16 | Per-lane write mask, bit l for lane l |
| dst_old_i | input | 512 | Previous destination value, same layout |
| res_valid_o | output | 1 | Registered result is valid |
| res_wen_o | output | 16 | Per-lane write enable |
| res_data_o | output | 512 | Merged result, same layout |

## Verification
The unit is driven with vectors whose lanes all differ, so a lane swap or a bad broadcast shows up as a lane mismatch. Carry-wrap sums, negative compare pairs and shift counts of 0 and 31, with junk in the upper bits of b, separate the arithmetic from near-miss variants. Predicated runs with irregular masks, an all-zero mask and scalar-only instructions under a conflicting mask tell the write-enable and merge logic apart from the ALU. Idle gaps between issues check that valid and write-enable fall back to zero.

// File: rtl/vlane_pkg.sv
package vlane_pkg;
   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_SUB = 3'd1,
      OP_AND = 3'd2,
      OP_OR  = 3'd3,
      OP_XOR = 3'd4,
      OP_SHL = 3'd5,
      OP_SHR = 3'd6,
      OP_SLT = 3'd7
   } vlane_op_e;
endpackage

// File: rtl/vlane_bcast.sv
// Operand selector: either pass each lane through or replicate lane 0.
module vlane_bcast #(
   parameter int LANES  = 16,
   parameter int DATA_W = 32
) (
   input  logic [LANES*DATA_W-1:0] bus_i,
   input  logic                    scalar_i,
   output logic [LANES*DATA_W-1:0] bus_o
);
   logic [DATA_W-1:0] word0;
   assign word0 = bus_i[DATA_W-1:0];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign bus_o[l*DATA_W +: DATA_W] = scalar_i ? word0 : bus_i[l*DATA_W +: DATA_W];
   end
endmodule

// File: rtl/vlane_lane.sv
// One lane of integer arithmetic.
module vlane_lane
   import vlane_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter bit SHARE_ADDER  = 1'b1
) (
   input  vlane_op_e         op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] y_o
);
   localparam int SH_W = $clog2(DATA_W);

   logic [DATA_W-1:0] sum;
   logic [SH_W-1:0]   shamt;
   logic              lt;

   assign shamt = b_i[SH_W-1:0];
   assign lt    = $signed(a_i) < $signed(b_i);

   if (SHARE_ADDER) begin : g_shared
      logic              inv;
      logic [DATA_W-1:0] b_mod;
      assign inv   = (op_i == OP_SUB);
      assign b_mod = inv ? ~b_i : b_i;
      assign sum   = a_i + b_mod + {{(DATA_W-1){1'b0}}, inv};
   end else begin : g_split
      logic [DATA_W-1:0] add_r;
      logic [DATA_W-1:0] sub_r;
      assign add_r = a_i + b_i;
      assign sub_r = a_i - b_i;
      assign sum   = (op_i == OP_SUB) ? sub_r : add_r;
   end

   always_comb begin
      unique case (op_i)
         OP_ADD,
         OP_SUB:  y_o = sum;
         OP_AND:  y_o = a_i & b_i;
         OP_OR:   y_o = a_i | b_i;
         OP_XOR:  y_o = a_i ^ b_i;
         OP_SHL:  y_o = a_i << shamt;
         OP_SHR:  y_o = a_i >> shamt;
         OP_SLT:  y_o = {{(DATA_W-1){1'b0}}, lt};
         default: y_o = '0;
      endcase
   end
endmodule

// File: rtl/vlane_wen.sv
// Per-lane write-enable generation.
module vlane_wen #(
   parameter int LANES = 16
) (
   input  logic             issue_i,
   input  logic             scalar_op_i,
   input  logic             pred_en_i,
   input  logic [LANES-1:0] mask_i,
   output logic [LANES-1:0] wen_o
);
   localparam logic [LANES-1:0] LANE0 = {{(LANES-1){1'b0}}, 1'b1};

   always_comb begin
      if (!issue_i)         wen_o = '0;
      else if (scalar_op_i) wen_o = LANE0;
      else if (pred_en_i)   wen_o = mask_i;
      else                  wen_o = '1;
   end
endmodule

// File: rtl/vec_lane_alu.sv
module vec_lane_alu
   import vlane_pkg::*;
#(
   parameter int LANES       = 16,
   parameter int DATA_W      = 32,
   parameter bit SHARE_ADDER = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    issue_i,
   input  logic [2:0]              op_i,
   input  logic [LANES*DATA_W-1:0] a_data_i,
   input  logic                    a_scalar_i,
   input  logic [LANES*DATA_W-1:0] b_data_i,
   input  logic                    b_scalar_i,
   input  logic                    scalar_op_i,
   input  logic                    pred_en_i,
   input  logic [LANES-1:0]        mask_i,
   input  logic [LANES*DATA_W-1:0] dst_old_i,
   output logic                    res_valid_o,
   output logic [LANES-1:0]        res_wen_o,
   output logic [LANES*DATA_W-1:0] res_data_o
);
   localparam int BUS_W = LANES * DATA_W;

   if (LANES < 2 || LANES > 64) begin : g_bad_lanes
      $error("vec_lane_alu: LANES must lie in 2..64");
   end
   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("vec_lane_alu: DATA_W must be a power of two of at least 8");
   end

   vlane_op_e        op;
   logic [BUS_W-1:0] a_bus, b_bus, y_bus, merged;
   logic [LANES-1:0] wen;

   assign op = vlane_op_e'(op_i);

   vlane_bcast #(.LANES(LANES), .DATA_W(DATA_W)) i_bcast_a (
      .bus_i(a_data_i), .scalar_i(a_scalar_i), .bus_o(a_bus));
   vlane_bcast #(.LANES(LANES), .DATA_W(DATA_W)) i_bcast_b (
      .bus_i(b_data_i), .scalar_i(b_scalar_i), .bus_o(b_bus));

   vlane_wen #(.LANES(LANES)) i_wen (
      .issue_i(issue_i), .scalar_op_i(scalar_op_i), .pred_en_i(pred_en_i),
      .mask_i(mask_i), .wen_o(wen));

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      vlane_lane #(.DATA_W(DATA_W), .SHARE_ADDER(SHARE_ADDER)) i_lane (
         .op_i(op),
         .a_i(a_bus[l*DATA_W +: DATA_W]),
         .b_i(b_bus[l*DATA_W +: DATA_W]),
         .y_o(y_bus[l*DATA_W +: DATA_W]));
      assign merged[l*DATA_W +: DATA_W] = wen[l] ? y_bus[l*DATA_W +: DATA_W]
                                                 : dst_old_i[l*DATA_W +: DATA_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid_o <= 1'b0;
         res_wen_o   <= '0;
         res_data_o  <= '0;
      end else begin
         res_valid_o <= issue_i;
         res_wen_o   <= wen;
         if (issue_i) res_data_o <= merged;
      end
   end
endmodule

// File: rtl/vec_lane_alu_chk.sv
module vec_lane_alu_chk #(
   parameter int LANES  = 16,
   parameter int DATA_W = 32
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    issue_i,
   input logic                    scalar_op_i,
   input logic                    pred_en_i,
   input logic [LANES-1:0]        mask_i,
   input logic [LANES*DATA_W-1:0] dst_old_i,
   input logic                    res_valid_o,
   input logic [LANES-1:0]        res_wen_o,
   input logic [LANES*DATA_W-1:0] res_data_o
);
   logic                    s_iss, s_sc, s_pe;
   logic [LANES-1:0]        s_mask;
   logic [LANES*DATA_W-1:0] s_old;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_iss <= 1'b0; s_sc <= 1'b0; s_pe <= 1'b0;
         s_mask <= '0; s_old <= '0;
      end else begin
         s_iss <= issue_i; s_sc <= scalar_op_i; s_pe <= pred_en_i;
         s_mask <= mask_i; s_old <= dst_old_i;
      end
   end

   AST_VALID_FOLLOWS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o == s_iss); // R9
   AST_IDLE_NO_WEN: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid_o |-> res_wen_o == '0); // R9
   AST_SCALAR_LANE0_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (s_iss && s_sc) |-> res_wen_o == {{(LANES-1){1'b0}}, 1'b1}); // R6
   AST_MASK_TO_WEN: assert property (@(posedge clk) disable iff (!rst_n)
      (s_iss && !s_sc && s_pe) |-> res_wen_o == s_mask); // R7
   AST_UNPRED_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (s_iss && !s_sc && !s_pe) |-> res_wen_o == '1); // R8

   for (genvar l = 0; l < LANES; l++) begin : g_keep
      AST_UNSELECTED_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
         (s_iss && !res_wen_o[l]) |->
            res_data_o[l*DATA_W +: DATA_W] == s_old[l*DATA_W +: DATA_W]); // R7
   end

   always_comb begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (!res_valid_o && res_wen_o == '0 && res_data_o == '0); // R10
      end
   end
endmodule

bind vec_lane_alu vec_lane_alu_chk #(.LANES(LANES), .DATA_W(DATA_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .scalar_op_i(scalar_op_i),
   .pred_en_i(pred_en_i), .mask_i(mask_i), .dst_old_i(dst_old_i),
   .res_valid_o(res_valid_o), .res_wen_o(res_wen_o), .res_data_o(res_data_o));

// File: tb/test_vec_lane_alu.sv
`timescale 1ns/1ps
module test_vec_lane_alu;
   localparam int LANES = 16;
   localparam int DW    = 32;
   localparam int BW    = LANES * DW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          issue_i = 1'b0;
   logic [2:0]    op_i = '0;
   logic [BW-1:0] a_data_i = '0, b_data_i = '0, dst_old_i = '0;
   logic          a_scalar_i = 1'b0, b_scalar_i = 1'b0;
   logic          scalar_op_i = 1'b0, pred_en_i = 1'b0;
   logic [LANES-1:0] mask_i = '0;
   logic          res_valid_o;
   logic [LANES-1:0] res_wen_o;
   logic [BW-1:0] res_data_o;

   always #2.5 clk = ~clk;

   vec_lane_alu i_vec_lane_alu (.*);

   int checks = 0;
   int errors = 0;
   bit mon_on = 1'b0;
   bit done   = 1'b0;

   logic [DW-1:0] a_v [LANES];
   logic [DW-1:0] b_v [LANES];
   logic [DW-1:0] o_v [LANES];

   logic [LANES-1:0] q_wen  [$];
   logic [BW-1:0]    q_data [$];
   string            q_tag  [$];

   function automatic logic [DW-1:0] model(input logic [2:0] op,
                                           input logic [DW-1:0] a, input logic [DW-1:0] b);
      case (op)
         3'd0: return a + b;
         3'd1: return a - b;
         3'd2: return a & b;
         3'd3: return a | b;
         3'd4: return a ^ b;
         3'd5: return a << b[4:0];
         3'd6: return a >> b[4:0];
         default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [BW-1:0] act, input logic [BW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic send(input logic [2:0] op, input bit as, input bit bs, input bit so,
                       input bit pe, input logic [LANES-1:0] mask, input string tag);
      logic [LANES-1:0] ew;
      logic [BW-1:0]    ed;
      @(negedge clk);
      issue_i = 1'b1; op_i = op; a_scalar_i = as; b_scalar_i = bs;
      scalar_op_i = so; pred_en_i = pe; mask_i = mask;
      for (int l = 0; l < LANES; l++) begin
         a_data_i[l*DW +: DW]  = a_v[l];
         b_data_i[l*DW +: DW]  = b_v[l];
         dst_old_i[l*DW +: DW] = o_v[l];
      end
      ew = so ? 16'h0001 : (pe ? mask : 16'hFFFF);
      for (int l = 0; l < LANES; l++) begin
         logic [DW-1:0] ea, eb;
         ea = as ? a_v[0] : a_v[l];
         eb = bs ? b_v[0] : b_v[l];
         ed[l*DW +: DW] = ew[l] ? model(op, ea, eb) : o_v[l];
      end
      q_wen.push_back(ew); q_data.push_back(ed); q_tag.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         issue_i = 1'b0;
      end
   endtask

   task automatic fill(input int seed);
      for (int l = 0; l < LANES; l++) begin
         a_v[l] = 32'h9E37_79B9 * (l + seed) ^ 32'h1234_5678;
         b_v[l] = 32'h85EB_CA6B * (l + 3 * seed + 1) + l;
         o_v[l] = 32'hD00D_0000 + (seed << 8) + l;
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (mon_on) begin
         if (res_valid_o) begin
            if (q_wen.size() == 0) begin
               check(1'b0, "R9", "unexpected valid", 1, 0);
            end else begin
               logic [LANES-1:0] ew;
               logic [BW-1:0]    ed;
               string            t;
               ew = q_wen.pop_front(); ed = q_data.pop_front(); t = q_tag.pop_front();
               check(res_wen_o == ew, t, "wen", res_wen_o, ew);
               check(res_data_o == ed, t, "data", res_data_o, ed);
            end
         end else begin
            check(res_wen_o == '0, "R9", "idle wen", res_wen_o, 0);
         end
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check(res_valid_o == 1'b0, "R10", "valid in reset", res_valid_o, 0);
      check(res_wen_o == '0, "R10", "wen in reset", res_wen_o, 0);
      check(res_data_o == '0, "R10", "data in reset", res_data_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      mon_on = 1'b1;

      // R1 add with wrap, sub; R8 unpredicated
      fill(1);
      a_v[3] = 32'hFFFF_FFFF; b_v[3] = 32'h0000_0002;
      send(3'd0, 0, 0, 0, 0, 16'h0000, "R1_R8");
      send(3'd1, 0, 0, 0, 0, 16'h1234, "R1_R8");
      // R2 logic ops back to back
      fill(2);
      send(3'd2, 0, 0, 0, 0, '0, "R2");
      send(3'd3, 0, 0, 0, 0, '0, "R2");
      send(3'd4, 0, 0, 0, 0, '0, "R2");
      idle(2); // R9 gap
      // R3 shifts: amounts 0, 31, and junk above bit 4
      fill(3);
      b_v[0] = 32'd0; b_v[1] = 32'd31; b_v[2] = 32'hFFFF_FFE5; b_v[3] = 32'h0000_0020;
      a_v[1] = 32'h8000_0001;
      send(3'd5, 0, 0, 0, 0, '0, "R3");
      send(3'd6, 0, 0, 0, 0, '0, "R3");
      // R4 signed compare with negatives and equality
      fill(4);
      a_v[0] = 32'hFFFF_FFFF; b_v[0] = 32'd1;
      a_v[1] = 32'd1;         b_v[1] = 32'hFFFF_FFFF;
      a_v[2] = 32'h8000_0000; b_v[2] = 32'h7FFF_FFFF;
      a_v[3] = 32'd5;         b_v[3] = 32'd5;
      send(3'd7, 0, 0, 0, 0, '0, "R4");
      // R5 scalar broadcast of b, then a, then both
      fill(5);
      send(3'd0, 0, 1, 0, 0, '0, "R5");
      send(3'd1, 1, 0, 0, 0, '0, "R5");
      send(3'd4, 1, 1, 0, 0, '0, "R5");
      idle(1);
      // R7 predicated masks
      fill(6);
      send(3'd0, 0, 0, 0, 1, 16'hA5C3, "R7");
      send(3'd3, 0, 1, 0, 1, 16'h8001, "R7");
      send(3'd2, 0, 0, 0, 1, 16'h0000, "R7");
      send(3'd6, 0, 0, 0, 1, 16'hFFFF, "R7");
      // R6 scalar-only with mask/pred that would say otherwise
      fill(7);
      send(3'd0, 0, 0, 1, 1, 16'h0000, "R6");
      send(3'd1, 0, 0, 1, 1, 16'hFFFE, "R6");
      send(3'd7, 0, 0, 1, 0, 16'h00F0, "R6");
      idle(4);

      check(q_wen.size() == 0, "R9", "results outstanding", q_wen.size(), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule